// File: doc/BRIEF.md
# Routable Level Interrupt Controller

This block gathers a set of level-sensitive interrupt sources and steers each one onto one of several interrupt lines toward a processor. Every source has an enable bit in a mask register. It also has a 4-bit route field that either picks an output line or leaves the source disconnected. Each output line is the OR of all enabled, asserted sources routed to it. It stays high for as long as any such source stays high.

Software reaches the block through a simple 32-bit register port with address, write enable, write data, read enable and read data. Software reads the raw source levels from a status register. It forms the serviceable set as the bitwise AND of that status and the mask. Inputs pass through a two-flop synchronizer, and the outputs are registered.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset, the mask register (offset 0x00) and the four route registers (offsets 0x08, 0x0C, 0x10, 0x14) read zero, and every output line is low.
- R2: Mask bit n enables source n. A write to offset 0x00 sets the whole mask, and a read of offset 0x00 returns the value written.
- R3: Offset 0x04 reads the synchronized raw source levels whatever the mask holds. A write to 0x04 changes neither the status nor the mask nor any route.
- R4: Source n's 4-bit route field lies in route register n/8 (offset 0x08 + 4*(n/8)), at bits [4*(n%8)+3 : 4*(n%8)]. Each route register reads back the value written to it.
- R5: Route code 0 connects the source to no output. Route code k in 1..15 drives output line k-1.
- R6: An output line is high exactly when at least one source that is enabled, asserted and routed to that line is high. Several sources may share one line.
- R7: A change on a source input shows at the outputs three clock cycles after the edge that samples it. That is two synchronizer stages plus one output register.
- R8: Writing zero to the mask drives all outputs low on the next output update, even while sources stay asserted.
- R9: When a source is masked or rerouted while it is asserted, the old line falls and the new line rises on the same output update, one cycle after the write.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Raw level interrupt sources |
| reg_addr | input | 8 | Byte offset of register access |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_ren | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data (registered, valid the cycle after reg_ren) |
| irq_line | output | 15 | Combined interrupt output lines |

## Verification
The bench builds the block with its default parameters: 32 sources, 15 lines, 4-bit route fields, 8-bit offsets. This puts every route register and every route code within reach, including code 0 and code 15. It also covers sources in both the first and the last route register. The three-cycle latency is checked at the exact cycle. Lines shared by several sources are checked as each source drops away.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ROUTE_W    = 4;
  localparam int unsigned OFF_MASK   = 8'h00;
  localparam int unsigned OFF_STATUS = 8'h04;
  localparam int unsigned OFF_ROUTE0 = 8'h08;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_ROUTE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_out = stage2_q;
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned N_RREG = (N_SRC * ROUTE_W + DATA_W - 1) / DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wen,
  input  logic [DATA_W-1:0]         reg_wdata,
  input  logic                      reg_ren,
  input  logic [N_SRC-1:0]          status,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic [N_SRC-1:0]          mask,
  output logic [N_SRC*ROUTE_W-1:0]  routes
);
  localparam int unsigned RIDX_W = (N_RREG > 1) ? $clog2(N_RREG) : 1;

  logic [DATA_W-1:0] mask_q, mask_d;
  logic [DATA_W-1:0] route_q [N_RREG];
  logic [DATA_W-1:0] route_d [N_RREG];
  logic [DATA_W-1:0] rdata_q, rdata_d;
  reg_sel_e          sel;
  logic [RIDX_W-1:0] ridx;
  logic [DATA_W-1:0] stat_ext;

  // Address decode
  always_comb begin
    sel  = SEL_NONE;
    ridx = '0;
    if (reg_addr == ADDR_W'(OFF_MASK)) begin
      sel = SEL_MASK;
    end else if (reg_addr == ADDR_W'(OFF_STATUS)) begin
      sel = SEL_STAT;
    end else begin
      for (int i = 0; i < N_RREG; i++) begin
        if (reg_addr == ADDR_W'(OFF_ROUTE0 + 4 * i)) begin
          sel  = SEL_ROUTE;
          ridx = RIDX_W'(i);
        end
      end
    end
  end

  always_comb begin
    stat_ext = '0;
    stat_ext[N_SRC-1:0] = status;
  end

  // Next state
  always_comb begin
    mask_d = mask_q;
    for (int i = 0; i < N_RREG; i++) route_d[i] = route_q[i];
    if (reg_wen) begin
      if (sel == SEL_MASK) mask_d = reg_wdata;
      if (sel == SEL_ROUTE) route_d[ridx] = reg_wdata;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_ren) begin
      unique case (sel)
        SEL_MASK:  rdata_d = mask_q;
        SEL_STAT:  rdata_d = stat_ext;
        SEL_ROUTE: rdata_d = route_q[ridx];
        default:   rdata_d = '0;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      rdata_q <= rdata_d;
    end
  end

  for (genvar g = 0; g < N_RREG; g++) begin : g_rreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[g] <= '0;
      else        route_q[g] <= route_d[g];
    end
  end

  // Flatten route fields
  for (genvar s = 0; s < N_SRC; s++) begin : g_flat
    localparam int unsigned REG_I = (s * ROUTE_W) / DATA_W;
    localparam int unsigned BIT_I = (s * ROUTE_W) % DATA_W;
    assign routes[s*ROUTE_W +: ROUTE_W] = route_q[REG_I][BIT_I +: ROUTE_W];
  end

  assign mask      = mask_q[N_SRC-1:0];
  assign reg_rdata = rdata_q;
endmodule

// File: rtl/lvl_irq_combine.sv
module lvl_irq_combine
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_LINE = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          level,
  input  logic [N_SRC-1:0]          mask,
  input  logic [N_SRC*ROUTE_W-1:0]  routes,
  output logic [N_LINE-1:0]         line_q
);
  logic [N_LINE-1:0] line_d;
  logic [N_SRC-1:0]  live;

  assign live = level & mask;

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    logic [N_SRC-1:0] hit;
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign hit[s] = live[s] &&
                      (routes[s*ROUTE_W +: ROUTE_W] == ROUTE_W'(l + 1));
    end
    assign line_d[l] = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_LINE = 15,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_ren,
  output logic [31:0]       reg_rdata,
  output logic [N_LINE-1:0] irq_line
);
  logic [N_SRC-1:0]         sync_lvl;
  logic [N_SRC-1:0]         mask;
  logic [N_SRC*ROUTE_W-1:0] routes;

  lvl_irq_sync #(.WIDTH(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(src_lvl), .d_out(sync_lvl)
  );

  lvl_irq_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_ren(reg_ren), .status(sync_lvl),
    .reg_rdata(reg_rdata), .mask(mask), .routes(routes)
  );

  lvl_irq_combine #(.N_SRC(N_SRC), .N_LINE(N_LINE)) u_comb (
    .clk(clk), .rst_n(rst_n), .level(sync_lvl), .mask(mask),
    .routes(routes), .line_q(irq_line)
  );
endmodule

// File: rtl/lvl_irq_router_chk.sv
module lvl_irq_router_chk #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_LINE = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  sync_lvl,
  input logic [N_SRC-1:0]  mask,
  input logic [N_LINE-1:0] irq_line
);
  // R8
  property all_masked_quiet;
    @(posedge clk) disable iff (!rst_n) (mask == '0) |=> (irq_line == '0);
  endproperty
  mask_zero_quiet_chk: assert property (all_masked_quiet);

  // R6
  property no_live_no_line;
    @(posedge clk) disable iff (!rst_n) ((sync_lvl & mask) == '0) |=> (irq_line == '0);
  endproperty
  idle_lines_low_chk: assert property (no_live_no_line);

  // R6
  property line_needs_live;
    @(posedge clk) disable iff (!rst_n) (irq_line != '0) |-> ($past(sync_lvl & mask) != '0);
  endproperty
  line_has_cause_chk: assert property (line_needs_live);

  // R1
  property reset_quiet;
    @(posedge clk) $rose(rst_n) |-> (irq_line == '0);
  endproperty
  reset_lines_low_chk: assert property (reset_quiet);
endmodule

bind lvl_irq_router lvl_irq_router_chk #(.N_SRC(N_SRC), .N_LINE(N_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .mask(mask), .irq_line(irq_line)
);

// File: tb/lvl_irq_router_bench.sv
module lvl_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ren = 1'b0;
  logic [31:0] reg_rdata;
  logic [14:0] irq_line;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  lvl_irq_router u_lvl_irq_router (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_addr(reg_addr),
    .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_ren(reg_ren),
    .reg_rdata(reg_rdata), .irq_line(irq_line)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, effective at the next posedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_ren = 1'b1;
    @(negedge clk);
    reg_ren = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 lines", {17'b0, irq_line}, 32'h0);
    rd(8'h00, v); check("R1 mask", v, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h08 + 8'(4*i), v); check("R1 route", v, 32'h0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(8'h00, 32'hA5A5_0F0F); rd(8'h00, v); check("R2 mask readback", v, 32'hA5A5_0F0F);
    wr(8'h10, 32'h1234_5678); rd(8'h10, v); check("R4 route2 readback", v, 32'h1234_5678);
    wr(8'h14, 32'hFEDC_BA98); rd(8'h14, v); check("R4 route3 readback", v, 32'hFEDC_BA98);
    wr(8'h00, 32'h0); wr(8'h10, 32'h0); wr(8'h14, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(8'h00, 32'h0);
    src_lvl = 32'h8000_0101;
    settle();
    rd(8'h04, v); check("R3 status ignores mask", v, 32'h8000_0101);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R3 status write ignored", v, 32'h8000_0101);
    rd(8'h00, v); check("R3 mask untouched", v, 32'h0);
    rd(8'h08, v); check("R3 route untouched", v, 32'h0);
    src_lvl = '0; settle();
  endtask

  task automatic t_route_codes();
    // src0 code 1 -> line0; src9 (reg1 bits 7:4) code 15 -> line14;
    // src31 (reg3 bits 31:28) code 8 -> line7; src2 code 0 -> none
    wr(8'h08, 32'h0000_0001);
    wr(8'h0C, 32'h0000_00F0);
    wr(8'h14, 32'h8000_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    src_lvl = 32'h0000_0004; settle();
    check("R5 code0 disconnected", {17'b0, irq_line}, 32'h0);
    src_lvl = 32'h8000_0201; settle();
    check("R4 R5 field mapping", {17'b0, irq_line}, 32'h0000_4081);
    src_lvl = '0; settle();
    check("R6 lines drop", {17'b0, irq_line}, 32'h0);
  endtask

  task automatic t_shared_line();
    // src0 and src9 both to line 3 (code 4)
    wr(8'h08, 32'h0000_0004);
    wr(8'h0C, 32'h0000_0040);
    src_lvl = 32'h0000_0201; settle();
    check("R6 shared both", {17'b0, irq_line}, 32'h0000_0008);
    src_lvl = 32'h0000_0200; settle();
    check("R6 shared one left", {17'b0, irq_line}, 32'h0000_0008);
    wr(8'h00, 32'hFFFF_FDFF); settle();
    check("R6 masked one gone", {17'b0, irq_line}, 32'h0);
    src_lvl = '0; wr(8'h00, 32'hFFFF_FFFF); settle();
  endtask

  task automatic t_latency();
    // src0 routed to line3 (code 4)
    @(negedge clk); src_lvl = 32'h1;
    @(negedge clk); check("R7 cycle1 low", {17'b0, irq_line}, 32'h0);
    @(negedge clk); check("R7 cycle2 low", {17'b0, irq_line}, 32'h0);
    @(negedge clk); check("R7 cycle3 high", {17'b0, irq_line}, 32'h8);
  endtask

  task automatic t_reroute_mask();
    // src0 asserted on line3; reroute to line 5 (code 6)
    @(negedge clk); reg_addr = 8'h08; reg_wdata = 32'h6; reg_wen = 1'b1;
    @(negedge clk); reg_wen = 1'b0;
    check("R9 still old line", {17'b0, irq_line}, 32'h8);
    @(negedge clk); check("R9 moved line", {17'b0, irq_line}, 32'h20);
    wr(8'h00, 32'h0);
    @(negedge clk); check("R8 mask zero quiet", {17'b0, irq_line}, 32'h0);
    wr(8'h00, 32'h1); @(negedge clk);
    check("R9 unmask returns", {17'b0, irq_line}, 32'h20);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R10 unmapped read 0x18", v, 32'h0);
    rd(8'hFC, v); check("R10 unmapped read 0xFC", v, 32'h0);
    rd(8'h00, v); check("R10 mask kept", v, 32'h1);
    rd(8'h08, v); check("R10 route kept", v, 32'h6);
    check("R10 line kept", {17'b0, irq_line}, 32'h20);
    src_lvl = '0; settle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_status();
    t_route_codes();
    t_shared_line();
    t_latency();
    t_reroute_mask();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule